// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block is the receive-side DMA engine of an Ethernet controller. It walks a list of 16-byte receive descriptors in memory through a simple synchronous 32-bit memory port. A descriptor is usable only while its ownership flag marks it as belonging to the engine. The engine packs the incoming byte stream into little-endian 32-bit words and stores them in that descriptor's buffer. It then writes back a status word that returns the descriptor to the host. A frame longer than one buffer spills into the following descriptors.

The host loads the list start address with `base_load`. The engine stops on the first descriptor the host still owns. A `poll_demand` pulse makes it read that same descriptor again. Frame bytes that arrive while the engine is stopped or not yet started are discarded, and each discarded frame is counted. MAC framing, FCS checking, address filtering and bus arbitration live elsewhere.

Descriptor layout (byte offset within a descriptor):
- +0 status
- +4 control and buffer size
- +8 buffer address
- +12 link address

The memory port accepts every request in the cycle it is made. Read data returns on `mem_rdata` one cycle after a read request.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset the engine is idle. It makes no memory request, holds `rx_ready` high, discards any bytes offered, and `missed_cnt` reads 0.
- R2: A `base_load` pulse in the idle or stopped state records `base_addr` as the list start. The engine then reads the four words of the descriptor at that address, in order at +0, +4, +8 and +12. It does not start while a discarded frame is still in progress or while `rx_valid` is high.
- R3: Into an owned descriptor, frame byte k is written to byte lane k mod 4 (bits 8*(k mod 4)+7 down to 8*(k mod 4)) of the word at buffer address + 4*floor(k/4). Words are written in ascending address order. The final partial word carries zeros in its unused lanes, and its byte enable is 0x1, 0x3 or 0x7 for 1, 2 or 3 valid bytes. Full words use 0xF.
- R4: After the last buffer write for a descriptor, the engine writes the status word to descriptor +0 with all byte enables set. No buffer write follows it before the next descriptor read. The status word layout:
  - bit 31 is 0, which hands the descriptor back to the host
  - bit 30 is set if this descriptor holds the first byte of the frame
  - bit 8 is set if it holds the last byte
  - bits 29:16 give the number of frame bytes received so far, FCS included
  - all other bits are 0
- R5: The buffer size is control word bits 10:0, and must be nonzero. When a buffer fills before the frame ends, its status has bit 8 clear. The frame then continues at byte offset 0 of the next descriptor, whose status has bit 30 clear. The engine never writes past the buffer size.
- R6: The next descriptor address is chosen by the control word, in this priority:
  - if bit 25 is set, the list start address
  - otherwise, if bit 24 is set, the link word (+12)
  - otherwise, the current address + 16
- R7: A descriptor whose status bit 31 reads 0 stops the engine. While stopped it makes no memory request, accepts and discards bytes, and adds one to `missed_cnt` for each discarded frame end. A frame cut off by a stop is also counted when its end arrives.
- R8: A `poll_demand` pulse while stopped makes the engine read the same descriptor address again. If a discarded frame is in progress, the read is held off until that frame has ended. A pulse in any other state has no effect.
- R9: `rx_ready` is low in every cycle in which the engine drives a memory request.
- R10: A frame whose last byte carries `rx_err` gets status bit 15 set in its final descriptor only. Earlier descriptors of the frame have bit 15 clear.
- R11: `missed_cnt` saturates at its maximum value (2^MISS_W - 1) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 32 | Descriptor list start address, taken on `base_load` |
| base_load | input | 1 | Pulse: take `base_addr` and start |
| poll_demand | input | 1 | Pulse: read the stopping descriptor again |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Frame has an error (sampled with `rx_last`) |
| rx_ready | output | 1 | Byte is taken this cycle when `rx_valid` is high |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, one cycle after the read request |
| missed_cnt | output | MISS_W | Saturating count of discarded frames |

## Verification
The bench builds a three-descriptor list that uses all three next-address rules, including one descriptor with both the end and link flags set. A design that gets the priority wrong would read a fourth address instead of returning to the start. One frame is spread across two buffers and ends with an error. A design that mishandles the split would put the first flag, the last flag or the error bit on the wrong status word, or would overrun the 8-byte buffer. Frames of 13, 4 and 6 bytes exercise the partial last word. Bytes outside the enabled lanes must keep their old values, which exposes wrong byte enables.

A poll demand is issued in the middle of a discarded frame. A design that acts on it at once would read the descriptor early and store the tail of the cut-off frame as a new frame. A final run of one-byte frames drives the missed-frame counter past its maximum, which shows whether it wraps.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int unsigned DESC_STRIDE = 16;
  localparam int unsigned FLEN_W      = 14;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FRD,
    S_FCAP,
    S_RECV,
    S_WDATA,
    S_WSTAT,
    S_SUSP
  } rxd_state_t;

  // Status word returned to the host; the ownership bit is always clear.
  function automatic logic [31:0] rxd_status(input logic first, input logic last,
                                             input logic err,
                                             input logic [FLEN_W-1:0] flen);
    logic [31:0] s;
    s        = '0;
    s[30]    = first;
    s[29:16] = flen;
    s[15]    = err & last;
    s[8]     = last;
    return s;
  endfunction

  // Next descriptor: end-of-list wins over the link word, which wins over stride.
  function automatic logic [31:0] rxd_next(input logic [31:0] cur, input logic [31:0] base,
                                           input logic [31:0] link,
                                           input logic wrap, input logic chain);
    if (wrap)       return base;
    else if (chain) return link;
    else            return cur + 32'(DESC_STRIDE);
  endfunction

endpackage

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int unsigned SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              take,
  input  logic [7:0]        byte_in,
  input  logic [SIZE_W-1:0] size,
  input  logic              drain,
  output logic [31:0]       word,
  output logic [3:0]        be,
  output logic [SIZE_W-1:0] off,
  output logic              at_end,
  output logic              lane_hi
);

  localparam int unsigned LANES = 4;

  logic [SIZE_W-1:0] off_q;
  logic [SIZE_W:0]   off_inc;

  assign off_inc = {1'b0, off_q} + 1'b1;
  assign at_end  = (off_inc == {1'b0, size});
  assign lane_hi = (off_q[1:0] == 2'd3);
  assign off     = off_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) off_q <= '0;
    else if (take)         off_q <= off_inc[SIZE_W-1:0];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] b_q;
    logic       e_q;
    always_ff @(posedge clk) begin
      if (!rst_n || restart || drain) begin
        b_q <= '0;
        e_q <= 1'b0;
      end else if (take && (off_q[1:0] == 2'(g))) begin
        b_q <= byte_in;
        e_q <= 1'b1;
      end
    end
    assign word[8*g +: 8] = b_q;
    assign be[g]          = e_q;
  end

  // R5: a byte is never taken at or beyond the buffer size
  a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (take && size != '0) |-> ({1'b0, off_q} < {1'b0, size}));

endmodule

// File: rtl/rxd_miss_ctr.sv
module rxd_miss_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (inc && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  // R11: once at the top the count stays there
  a_r11_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV) |=> (cnt_q == MAXV));

endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int unsigned SIZE_W = 11,
  parameter int unsigned MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       base_addr,
  input  logic              base_load,
  input  logic              poll_demand,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_err,
  output logic              rx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  output logic [MISS_W-1:0] missed_cnt
);
  import rxd_pkg::*;

  localparam int unsigned OWN_BIT   = 31;
  localparam int unsigned WRAP_BIT  = 25;
  localparam int unsigned CHAIN_BIT = 24;

  rxd_state_t state_q;

  logic [31:0]       cur_q, base_q, buf_q, link_q, wr_addr_q;
  logic [SIZE_W-1:0] size_q;
  logic              wrap_q, chain_q;
  logic [1:0]        idx_q;
  logic [FLEN_W-1:0] flen_q;
  logic              in_frame_q, desc_first_q, kick_q;
  logic              end_q, err_q, full_q;

  // named internal events
  logic accept, take, drop_byte, miss_inc, data_wr, stat_wr, fetch_go, restart;
  logic waiting, kick_now, flush_now;

  logic [31:0]       pk_word;
  logic [3:0]        pk_be;
  logic [SIZE_W-1:0] pk_off;
  logic              pk_at_end, pk_lane_hi;

  assign waiting   = (state_q == S_IDLE) || (state_q == S_SUSP);
  assign rx_ready  = waiting || (state_q == S_RECV);
  assign accept    = rx_valid && rx_ready;
  assign take      = accept && (state_q == S_RECV);
  assign drop_byte = accept && waiting;
  assign miss_inc  = drop_byte && rx_last;
  assign data_wr   = (state_q == S_WDATA);
  assign stat_wr   = (state_q == S_WSTAT);
  assign restart   = (state_q == S_FCAP) && (idx_q == 2'd3);
  assign flush_now = take && (pk_lane_hi || rx_last || pk_at_end);
  assign kick_now  = base_load || (poll_demand && state_q == S_SUSP);
  assign fetch_go  = waiting && (kick_q || kick_now) && !in_frame_q && !rx_valid;

  rxd_packer #(.SIZE_W(SIZE_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .take    (take),
    .byte_in (rx_data),
    .size    (size_q),
    .drain   (data_wr),
    .word    (pk_word),
    .be      (pk_be),
    .off     (pk_off),
    .at_end  (pk_at_end),
    .lane_hi (pk_lane_hi)
  );

  rxd_miss_ctr #(.W(MISS_W)) u_miss (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (miss_inc),
    .count (missed_cnt)
  );

  // frame tracking is shared by storing and discarding paths
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      flen_q     <= '0;
    end else if (accept) begin
      in_frame_q <= !rx_last;
      flen_q     <= in_frame_q ? flen_q + 1'b1 : FLEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      cur_q        <= '0;
      base_q       <= '0;
      buf_q        <= '0;
      link_q       <= '0;
      wr_addr_q    <= '0;
      size_q       <= '0;
      wrap_q       <= 1'b0;
      chain_q      <= 1'b0;
      idx_q        <= '0;
      desc_first_q <= 1'b0;
      kick_q       <= 1'b0;
      end_q        <= 1'b0;
      err_q        <= 1'b0;
      full_q       <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE, S_SUSP: begin
          if (base_load) begin
            base_q <= base_addr;
            cur_q  <= base_addr;
          end
          if (fetch_go) begin
            kick_q  <= 1'b0;
            idx_q   <= '0;
            state_q <= S_FRD;
          end else if (kick_now && (state_q == S_SUSP || base_load)) begin
            kick_q <= 1'b1;
          end
        end
        S_FRD: state_q <= S_FCAP;
        S_FCAP: begin
          case (idx_q)
            2'd0: ;
            2'd1: begin
              size_q  <= mem_rdata[SIZE_W-1:0];
              wrap_q  <= mem_rdata[WRAP_BIT];
              chain_q <= mem_rdata[CHAIN_BIT];
            end
            2'd2: buf_q  <= mem_rdata;
            default: link_q <= mem_rdata;
          endcase
          if (idx_q == 2'd0 && !mem_rdata[OWN_BIT]) begin
            state_q <= S_SUSP;
          end else if (idx_q == 2'd3) begin
            end_q   <= 1'b0;
            err_q   <= 1'b0;
            full_q  <= 1'b0;
            state_q <= S_RECV;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_FRD;
          end
        end
        S_RECV: begin
          if (take) begin
            if (pk_off == '0) desc_first_q <= !in_frame_q;
            wr_addr_q <= buf_q + 32'({pk_off[SIZE_W-1:2], 2'b00});
            end_q     <= rx_last;
            err_q     <= rx_last && rx_err;
            full_q    <= pk_at_end;
          end
          if (flush_now) state_q <= S_WDATA;
        end
        S_WDATA: state_q <= (end_q || full_q) ? S_WSTAT : S_RECV;
        S_WSTAT: begin
          cur_q   <= rxd_next(cur_q, base_q, link_q, wrap_q, chain_q);
          idx_q   <= '0;
          state_q <= S_FRD;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = 4'h0;
    case (state_q)
      S_FRD: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + {28'd0, idx_q, 2'b00};
        mem_be   = 4'hF;
      end
      S_WDATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = wr_addr_q;
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      S_WSTAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q;
        mem_wdata = rxd_status(desc_first_q, end_q, err_q, flen_q);
        mem_be    = 4'hF;
      end
      default: ;
    endcase
  end

  // R9: the byte stream is held off whenever memory is in use
  a_r9_ready_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rx_ready);

  // R3: buffer byte enables are packed from lane 0
  a_r3_be_packed: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF));

  // R4: the status write is followed by a descriptor read, not by more data
  a_r4_status_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (mem_req && !mem_we));

  // R7: a discarded frame end always moves the counter unless saturated
  a_r7_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_inc && missed_cnt != '1) |=> (missed_cnt != $past(missed_cnt)));

endmodule

// File: tb/sim_rx_ring_dma.sv
module sim_rx_ring_dma;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_addr = '0;
  logic        base_load = 1'b0, poll_demand = 1'b0;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [3:0]  missed_cnt;

  always #2.5 clk = ~clk;

  rx_ring_dma #(.SIZE_W(11), .MISS_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .base_load(base_load),
    .poll_demand(poll_demand), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .rx_ready(rx_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata), .missed_cnt(missed_cnt)
  );

  // memory model, 1 KiB, host writes go through the same process
  logic [31:0] mem [0:255];
  logic        hw_en = 1'b0;
  logic [31:0] hw_addr = '0, hw_data = '0;
  logic [31:0] fetch_log [0:15];
  int          n_fetch = 0, order_bad = 0, ready_bad = 0;
  logic        stat_seen = 1'b0;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) mem[k] <= 32'hDEADBEEF;
      mem_rdata <= '0;
    end else begin
      if (hw_en) mem[hw_addr[9:2]] <= hw_data;
      if (mem_req) begin
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end else begin
          mem_rdata <= mem[mem_addr[9:2]];
        end
      end
    end
  end

  // traffic monitors
  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_req && rx_ready) ready_bad++;
      if (mem_req && !mem_we && mem_addr[3:0] == 4'h0 && mem_addr < 32'h100) begin
        if (n_fetch < 16) fetch_log[n_fetch] = mem_addr;
        n_fetch++;
      end
      if (mem_req && !mem_we) stat_seen = 1'b0;
      if (mem_req && mem_we && mem_addr < 32'h100) stat_seen = 1'b1;
      if (mem_req && mem_we && mem_addr >= 32'h100 && stat_seen) order_bad++;
    end
  end

  function automatic logic [7:0] byte_of(int seed, int i);
    return 8'((seed * 16 + i * 3 + 1) & 255);
  endfunction

  function automatic logic [31:0] exp_status(bit first, bit last, bit err, int len);
    return (first ? 32'h4000_0000 : 0) | (last ? 32'h100 : 0) |
           ((err && last) ? 32'h8000 : 0) | (32'(len) << 16);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(logic [31:0] a, logic [31:0] d);
    @(negedge clk); hw_en = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk); hw_en = 1'b0;
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll_demand = 1'b1;
    @(negedge clk); poll_demand = 1'b0;
  endtask

  task automatic send_part(int seed, int from, int upto, int total, bit err);
    for (int i = from; i < upto; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = byte_of(seed, i);
      rx_last = (i == total - 1); rx_err = err && (i == total - 1);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // compare 'count' bytes of frame bytes starting at frame index 'first'
  task automatic check_buf(string tag, logic [31:0] addr, int seed, int first, int count);
    bit ok = 1;
    logic [7:0] a = 0, e = 0;
    for (int i = 0; i < count; i++) begin
      logic [31:0] ba;
      ba = addr + 32'(i);
      if (ok && mem[ba[9:2]][8*ba[1:0] +: 8] != byte_of(seed, first + i)) begin
        ok = 0; a = mem[ba[9:2]][8*ba[1:0] +: 8]; e = byte_of(seed, first + i);
      end
    end
    chk(ok, tag, {24'd0, a}, {24'd0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_log [0:7];
    exp_log[0] = 32'h000; exp_log[1] = 32'h040; exp_log[2] = 32'h050; exp_log[3] = 32'h000;
    exp_log[4] = 32'h000; exp_log[5] = 32'h040; exp_log[6] = 32'h040; exp_log[7] = 32'h050;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(2);
    // R1 reset state
    chk(!mem_req, "R1 no request after reset", {31'd0, mem_req}, 0);
    chk(rx_ready, "R1 ready while idle", {31'd0, rx_ready}, 1);
    chk(missed_cnt == 0, "R1 missed count zero", {28'd0, missed_cnt}, 0);

    // R1/R7: bytes while idle are dropped and counted
    send_part(9, 0, 3, 3, 0);
    wait_cyc(2);
    chk(missed_cnt == 1, "R1 idle frame counted", {28'd0, missed_cnt}, 1);

    // list: d0 chained to 0x040, d1 plain (stride), d2 wrap+chain (wrap wins)
    host_write(32'h000, 32'h8000_0000); host_write(32'h004, 32'h0100_0040);
    host_write(32'h008, 32'h0000_0100); host_write(32'h00C, 32'h0000_0040);
    host_write(32'h040, 32'h8000_0000); host_write(32'h044, 32'h0000_0008);
    host_write(32'h048, 32'h0000_0200); host_write(32'h04C, 32'h0000_0000);
    host_write(32'h050, 32'h8000_0000); host_write(32'h054, 32'h0300_0010);
    host_write(32'h058, 32'h0000_0280); host_write(32'h05C, 32'h0000_00C0);

    @(negedge clk); base_addr = 32'h0; base_load = 1'b1;
    @(negedge clk); base_load = 1'b0;
    wait_cyc(20);
    chk(n_fetch == 1, "R2 first descriptor read", n_fetch, 1);

    // F1: 13 bytes in d0
    send_part(1, 0, 13, 13, 0);
    wait_cyc(20);
    chk(mem[0] == exp_status(1, 1, 0, 13), "R4 d0 status F1", mem[0], exp_status(1, 1, 0, 13));
    check_buf("R3 F1 data", 32'h100, 1, 0, 13);
    chk(mem[67][31:8] == 24'hDEADBE, "R3 F1 partial word lanes", {8'd0, mem[67][31:8]}, 32'hDEADBE);

    // F2: 19 bytes with error, split over d1 (8) and d2 (11)
    send_part(2, 0, 19, 19, 1);
    wait_cyc(30);
    chk(mem[16] == exp_status(1, 0, 0, 8), "R5 d1 status F2 first part", mem[16], exp_status(1, 0, 0, 8));
    chk(mem[20] == exp_status(0, 1, 1, 19), "R10 d2 status F2 last with error", mem[20], exp_status(0, 1, 1, 19));
    check_buf("R5 F2 data in d1", 32'h200, 2, 0, 8);
    chk(mem[130] == 32'hDEADBEEF, "R5 no write past d1 buffer", mem[130], 32'hDEADBEEF);
    check_buf("R5 F2 data in d2", 32'h280, 2, 8, 11);
    chk(n_fetch == 4, "R6 wrap to list start", n_fetch, 4);

    // F3 while stopped: dropped
    send_part(3, 0, 5, 5, 0);
    wait_cyc(10);
    chk(missed_cnt == 2, "R7 stopped frame counted", {28'd0, missed_cnt}, 2);
    check_buf("R7 d0 buffer untouched", 32'h100, 1, 0, 13);
    chk(n_fetch == 4, "R7 no reads while stopped", n_fetch, 4);

    // poll after host returns d0
    host_write(32'h000, 32'h8000_0000);
    pulse_poll();
    wait_cyc(20);
    send_part(4, 0, 4, 4, 0);
    wait_cyc(20);
    chk(mem[0] == exp_status(1, 1, 0, 4), "R8 d0 status after poll", mem[0], exp_status(1, 1, 0, 4));
    check_buf("R3 F4 full word", 32'h100, 4, 0, 4);
    chk(n_fetch == 6, "R6 chained read after F4", n_fetch, 6);

    // deferred poll in the middle of a dropped frame
    host_write(32'h040, 32'h8000_0000);
    send_part(5, 0, 3, 10, 0);
    pulse_poll();
    wait_cyc(10);
    chk(n_fetch == 6, "R8 poll held during dropped frame", n_fetch, 6);
    send_part(5, 3, 10, 10, 0);
    wait_cyc(20);
    chk(n_fetch == 7, "R8 poll honoured after frame end", n_fetch, 7);
    chk(missed_cnt == 3, "R7 cut frame counted", {28'd0, missed_cnt}, 3);

    send_part(6, 0, 6, 6, 0);
    wait_cyc(20);
    chk(mem[16] == exp_status(1, 1, 0, 6), "R8 d1 status F6", mem[16], exp_status(1, 1, 0, 6));
    check_buf("R8 F6 data not mixed with dropped frame", 32'h200, 6, 0, 6);

    // saturation
    for (int k = 0; k < 13; k++) send_part(7, 0, 1, 1, 0);
    wait_cyc(5);
    chk(missed_cnt == 4'hF, "R11 missed count saturates", {28'd0, missed_cnt}, 32'hF);

    chk(n_fetch == 8, "R6 total descriptor reads", n_fetch, 8);
    for (int k = 0; k < 8; k++)
      chk(fetch_log[k] == exp_log[k], "R6 descriptor read address", fetch_log[k], exp_log[k]);
    chk(order_bad == 0, "R4 no data write after status", order_bad, 0);
    chk(ready_bad == 0, "R9 ready low during memory use", ready_bad, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule